// File: doc/BRIEF.md
# Host Adapter Control Register Block

This block is the register window that a 16-bit host processor sees when it talks to an add-on processing adapter. The host reaches it through a plain byte- and word-addressable access port. Every access is one cycle: the host raises a request with an address, a direction and a width. Write data is taken in that same cycle. Read data comes back one cycle later, marked by a valid strobe. The window holds three things. The first is the adapter control register, with an enable bit, an active-low slave release bit, an FM select bit and a read-only ready flag. The second is a DMA request length register. The third is a 16-byte mailbox area shared with the slave processors. At a separate address there is also a fixed four-character identification tag that the host reads to detect that the adapter is present.

The adapter-enable bit decides what the host may change. Before enable, only the mailbox accepts data. Every other write is dropped, except a write that sets the enable bit. Setting enable forces the slave release bit low. That same write is then treated as an ordinary control write, so it can release the slaves at once. Whenever the release bit goes from 0 to 1, the block sends a one-clock reset pulse to each slave processor. Enable cannot be cleared by software; only the system reset clears it.

Top module: `adp_host_regs`

## Requirements
- R1: After system reset (`rst` high, synchronous), the control word reads 0x0082, the length register and all mailbox bytes read 0, `adapter_en` is 0, and no `slave_rst` bit is high.
- R2: The control word at offset 0x00 always reads as follows: bit 15 is FM select, bit 7 is the ready flag and is always 1, bit 1 is slave release, bit 0 is enable, and all other bits are 0. Offsets 0x00 to 0x3F are readable whether or not the adapter is enabled.
- R3: The mailbox at offsets 0x20 to 0x2F accepts word and byte writes at all times. A word write stores `wdata[15:8]` at the even byte and `wdata[7:0]` at the odd byte. A byte write stores `wdata[7:0]` at the addressed byte.
- R4: While enable is 0, a write to the control word that does not set enable changes nothing, and a write to the length register changes nothing.
- R5: A write that sets enable while it is 0 (a word write to offset 0x00, or a byte write to offset 0x01, with `wdata[0]`=1) sets enable and clears slave release. It then applies the same write as a normal control write. As a result, a `wdata[1]` of 1 in that write releases the slaves and pulses them.
- R6: Once enabled, a word write to the control word updates only FM select (`wdata[15]`) and slave release (`wdata[1]`). A byte write to offset 0x00 updates only FM select (`wdata[7]`). A byte write to offset 0x01 updates only slave release (`wdata[1]`). Enable stays 1 until system reset.
- R7: When a control write changes slave release from 0 to 1, every `slave_rst` bit is high for exactly the one cycle after that write. A write that leaves slave release at 1 gives no pulse.
- R8: Writes to the length register at offset 0x10 (enabled only) store the data with bits 1:0 forced to 0. A byte write to offset 0x10 updates bits 15:8, and a byte write to offset 0x11 updates bits 7:0.
- R9: The identification tag at offsets 0xEC to 0xEF reads as ASCII "MARS". A word read at 0xEC returns 0x4D41 and a word read at 0xEE returns 0x5253. Writes to the tag have no effect.
- R10: A read of any other offset returns 0, and a write to any other offset has no effect.
- R11: A byte read returns the addressed byte in `rd_data[7:0]` with `rd_data[15:8]`=0. An even address selects bits 15:8 of the 16-bit register and an odd address selects bits 7:0. A word read ignores address bit 0.
- R12: `rd_valid` is high for the one cycle after each read request, and `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_valid | input | 1 | Host access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 16 | Read data |
| slave_rst | output | NUM_SLAVES | One-cycle reset pulse, one bit per slave processor |
| adapter_en | output | 1 | Adapter enable status |

## Verification
The assertions assume that the host issues at most one access per cycle. They also assume that `bus_valid` is low during reset, so the one-cycle history terms that follow a write or a read always refer to an access made after reset. The bench drives each access for exactly one cycle and then lowers `bus_valid` for at least one cycle. The random phase draws addresses only from the mapped offsets and from a few unmapped ones inside and outside the window. It enables the adapter partway through, so that both the gated and the open write paths are exercised.

// File: rtl/adp_pkg.sv
package adp_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CTRL,
    RG_LEN,
    RG_COMM,
    RG_TAG
  } region_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_NRES_BIT = 1;
  localparam int CTRL_RDY_BIT  = 7;
  localparam int CTRL_FM_BIT   = 15;

  localparam logic [15:0] TAG_LO_WORD = 16'h4D41;
  localparam logic [15:0] TAG_HI_WORD = 16'h5253;

  function automatic logic [15:0] tag_word(input logic upper);
    return upper ? TAG_HI_WORD : TAG_LO_WORD;
  endfunction

endpackage

// File: rtl/adp_bus_decode.sv
module adp_bus_decode
  import adp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN_BYTES = 64,
  parameter int COMM_BYTES = 16,
  parameter int IDX_W = 3,
  parameter logic [ADDR_W-1:0] LEN_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] COMM_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] TAG_BASE = 8'hEC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  output region_e           region,
  output logic              lane_hi,
  output logic              lane_lo,
  output logic [IDX_W-1:0]  comm_idx
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam logic [ADDR_W:0] COMM_END = (ADDR_W+1)'(COMM_BASE) + (ADDR_W+1)'(COMM_BYTES);

  logic in_win, is_ctrl, is_len, is_comm, is_tag;

  always_comb begin
    in_win  = (addr[ADDR_W-1:WIN_AW] == '0);
    is_ctrl = in_win && (addr[WIN_AW-1:1] == '0);
    is_len  = in_win && (addr[WIN_AW-1:1] == LEN_OFS[WIN_AW-1:1]);
    is_comm = ({1'b0, addr} >= {1'b0, COMM_BASE}) && ({1'b0, addr} < COMM_END);
    is_tag  = (addr[ADDR_W-1:2] == TAG_BASE[ADDR_W-1:2]);
    if (is_ctrl)      region = RG_CTRL;
    else if (is_len)  region = RG_LEN;
    else if (is_comm) region = RG_COMM;
    else if (is_tag)  region = RG_TAG;
    else              region = RG_NONE;
    lane_hi  = word || !addr[0];
    lane_lo  = word || addr[0];
    comm_idx = addr[IDX_W:1] - COMM_BASE[IDX_W:1];
  end
endmodule

// File: rtl/adp_ctrl_reg.sv
module adp_ctrl_reg
  import adp_pkg::*;
#(
  parameter int NUM_SLAVES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  lane_hi,
  input  logic                  lane_lo,
  input  logic                  fm_in,
  input  logic                  nres_in,
  input  logic                  en_in,
  output logic [15:0]           ctrl_word,
  output logic                  enabled,
  output logic [NUM_SLAVES-1:0] slave_pulse
);
  logic en_q, nres_q, fm_q;
  logic turning_on, accept, nres_base, pulse_next;

  always_comb begin
    turning_on = wr_en && !en_q && lane_lo && en_in;
    accept     = wr_en && (en_q || turning_on);
    nres_base  = turning_on ? 1'b0 : nres_q;
    pulse_next = accept && lane_lo && nres_in && !nres_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      nres_q <= 1'b1;
      fm_q   <= 1'b0;
    end else if (accept) begin
      en_q   <= 1'b1;
      nres_q <= lane_lo ? nres_in : nres_base;
      if (lane_hi) fm_q <= fm_in;
    end
  end

  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) slave_pulse[s] <= 1'b0;
      else     slave_pulse[s] <= pulse_next;
    end
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_FM_BIT]   = fm_q;
    ctrl_word[CTRL_RDY_BIT]  = 1'b1;
    ctrl_word[CTRL_NRES_BIT] = nres_q;
    ctrl_word[CTRL_EN_BIT]   = en_q;
    enabled                  = en_q;
  end
endmodule

// File: rtl/adp_len_reg.sv
module adp_len_reg #(
  parameter int LEN_W = 16,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             lane_hi,
  input  logic             lane_lo,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] len_q
);
  localparam int HALF = LEN_W / 2;
  localparam logic [LEN_W-1:0] KEEP = {{(LEN_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [LEN_W-1:0] masked;
  assign masked = wdata & KEEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (wr_en) begin
      if (lane_hi) len_q[LEN_W-1:HALF] <= masked[LEN_W-1:HALF];
      if (lane_lo) len_q[HALF-1:0]     <= masked[HALF-1:0];
    end
  end
endmodule

// File: rtl/adp_comm_window.sv
module adp_comm_window #(
  parameter int WORDS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             lane_hi,
  input  logic             lane_lo,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  output logic [15:0]      rd_word
);
  logic [15:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[w] <= '0;
      end else if (wr_en && (idx == IDX_W'(w))) begin
        if (lane_hi) mem[w][15:8] <= wdata[15:8];
        if (lane_lo) mem[w][7:0]  <= wdata[7:0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++)
      if (idx == IDX_W'(w)) rd_word = mem[w];
  end
endmodule

// File: rtl/adp_host_regs.sv
module adp_host_regs
  import adp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_SLAVES = 2,
  parameter int COMM_BYTES = 16,
  parameter logic [ADDR_W-1:0] LEN_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] COMM_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] TAG_BASE = 8'hEC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic                  bus_word,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [15:0]           bus_wdata,
  output logic                  rd_valid,
  output logic [15:0]           rd_data,
  output logic [NUM_SLAVES-1:0] slave_rst,
  output logic                  adapter_en
);
  localparam int WIN_BYTES  = 64;
  localparam int COMM_WORDS = COMM_BYTES / 2;
  localparam int IDX_W      = (COMM_WORDS > 1) ? $clog2(COMM_WORDS) : 1;

  region_e          region;
  logic             lane_hi, lane_lo;
  logic [IDX_W-1:0] comm_idx;
  logic [15:0]      wdata_al, ctrl_word, len_word, comm_word;
  logic [15:0]      word_val, rd_next;
  logic [7:0]       byte_val;
  logic             wr, rd;

  adp_bus_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .COMM_BYTES(COMM_BYTES), .IDX_W(IDX_W),
    .LEN_OFS(LEN_OFS), .COMM_BASE(COMM_BASE), .TAG_BASE(TAG_BASE)
  ) u_dec (
    .addr(bus_addr), .word(bus_word), .region(region),
    .lane_hi(lane_hi), .lane_lo(lane_lo), .comm_idx(comm_idx)
  );

  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign wdata_al = bus_word ? bus_wdata : {bus_wdata[7:0], bus_wdata[7:0]};

  adp_ctrl_reg #(.NUM_SLAVES(NUM_SLAVES)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(wr && (region == RG_CTRL)),
    .lane_hi(lane_hi), .lane_lo(lane_lo),
    .fm_in(wdata_al[CTRL_FM_BIT]), .nres_in(wdata_al[CTRL_NRES_BIT]),
    .en_in(wdata_al[CTRL_EN_BIT]),
    .ctrl_word(ctrl_word), .enabled(adapter_en), .slave_pulse(slave_rst)
  );

  adp_len_reg #(.LEN_W(16), .ALIGN_BITS(2)) u_len (
    .clk(clk), .rst(rst),
    .wr_en(wr && (region == RG_LEN) && adapter_en),
    .lane_hi(lane_hi), .lane_lo(lane_lo), .wdata(wdata_al), .len_q(len_word)
  );

  adp_comm_window #(.WORDS(COMM_WORDS), .IDX_W(IDX_W)) u_comm (
    .clk(clk), .rst(rst),
    .wr_en(wr && (region == RG_COMM)),
    .lane_hi(lane_hi), .lane_lo(lane_lo), .idx(comm_idx),
    .wdata(wdata_al), .rd_word(comm_word)
  );

  always_comb begin
    unique case (region)
      RG_CTRL: word_val = ctrl_word;
      RG_LEN:  word_val = len_word;
      RG_COMM: word_val = comm_word;
      RG_TAG:  word_val = tag_word(bus_addr[1]);
      default: word_val = '0;
    endcase
    byte_val = bus_addr[0] ? word_val[7:0] : word_val[15:8];
    rd_next  = bus_word ? word_val : {8'h00, byte_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/adp_host_regs_chk.sv
module adp_host_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int NUM_SLAVES = 2,
  parameter logic [ADDR_W-1:0] TAG_BASE = 8'hEC
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic                  bus_word,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  rd_valid,
  input logic [15:0]           rd_data,
  input logic [NUM_SLAVES-1:0] slave_rst,
  input logic                  adapter_en
);
  logic is_read, tag_lo_read, ctrl_read;
  assign is_read     = bus_valid && !bus_write;
  assign tag_lo_read = is_read && bus_word && (bus_addr[ADDR_W-1:2] == TAG_BASE[ADDR_W-1:2]) && !bus_addr[1];
  assign ctrl_read   = is_read && bus_word && (bus_addr[ADDR_W-1:1] == '0);

  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    slave_rst[0] |=> !slave_rst[0]);

  assert_pulse_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(slave_rst[0]) |-> $past(bus_valid && bus_write));

  assert_pulse_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    slave_rst[0] |-> adapter_en);

  assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    adapter_en |=> adapter_en);

  assert_enable_by_write_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(adapter_en) |-> $past(bus_valid && bus_write));

  assert_read_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    is_read |=> rd_valid);

  assert_no_spurious_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    !is_read |=> !rd_valid);

  assert_tag_word_R9: assert property (@(posedge clk) disable iff (rst)
    tag_lo_read |=> (rd_data == 16'h4D41));

  assert_ready_flag_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_read |=> rd_data[7]);
endmodule

bind adp_host_regs adp_host_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_SLAVES(NUM_SLAVES), .TAG_BASE(TAG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_word(bus_word), .bus_addr(bus_addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .slave_rst(slave_rst), .adapter_en(adapter_en)
);

// File: tb/adp_host_regs_tb.sv
`timescale 1ns/100ps
module adp_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_write, bus_word;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [1:0]  slave_rst;
  logic        adapter_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          m_en, m_nres, m_fm;
  logic [15:0] m_len;
  logic [7:0]  m_comm [16];

  always #2.5 clk = ~clk;

  adp_host_regs u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .slave_rst(slave_rst),
    .adapter_en(adapter_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_nres = 1; m_fm = 0; m_len = '0;
    for (int i = 0; i < 16; i++) m_comm[i] = '0;
  endtask

  function automatic bit model_write(input bit word, input logic [7:0] a, input logic [15:0] d);
    bit hi, lo, on, base, p;
    logic [15:0] al;
    p  = 0;
    hi = word || !a[0];
    lo = word || a[0];
    al = word ? d : {d[7:0], d[7:0]};
    if (a < 8'h40 && a[5:1] == 5'd0) begin
      on = !m_en && lo && al[0];
      if (m_en || on) begin
        base = on ? 1'b0 : m_nres;
        m_en = 1;
        if (hi) m_fm = al[15];
        if (lo) begin p = al[1] && !base; m_nres = al[1]; end
        else m_nres = base;
      end
    end else if (a < 8'h40 && a[5:1] == 5'd8) begin
      if (m_en) begin
        if (hi) m_len[15:8] = al[15:8];
        if (lo) m_len[7:0]  = al[7:0] & 8'hFC;
      end
    end else if (a >= 8'h20 && a < 8'h30) begin
      if (word) begin
        m_comm[{a[3:1], 1'b0}] = d[15:8];
        m_comm[{a[3:1], 1'b1}] = d[7:0];
      end else m_comm[a[3:0]] = d[7:0];
    end
    return p;
  endfunction

  function automatic logic [15:0] model_read(input bit word, input logic [7:0] a);
    logic [15:0] w;
    if (a < 8'h40 && a[5:1] == 5'd0)      w = {m_fm, 7'd0, 1'b1, 5'd0, m_nres, m_en};
    else if (a < 8'h40 && a[5:1] == 5'd8) w = m_len;
    else if (a >= 8'h20 && a < 8'h30)     w = {m_comm[{a[3:1], 1'b0}], m_comm[{a[3:1], 1'b1}]};
    else if (a[7:2] == 6'h3B)             w = a[1] ? 16'h5253 : 16'h4D41;
    else                                  w = 16'h0000;
    if (word) return w;
    return {8'h00, a[0] ? w[7:0] : w[15:8]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; bus_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic wr(input bit word, input logic [7:0] a, input logic [15:0] d, input string req);
    bit p;
    p = model_write(word, a, d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0;
    chk(slave_rst == {2{p}}, {req, " R7 pulse"}, 32'(slave_rst), 32'({2{p}}));
    chk(adapter_en == m_en, {req, " R5 enable"}, 32'(adapter_en), 32'(m_en));
  endtask

  task automatic rd(input bit word, input logic [7:0] a, input string req);
    logic [15:0] e;
    e = model_read(word, a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_word = word; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    chk(rd_valid === 1'b1, {req, " R12 valid"}, 32'(rd_valid), 32'd1);
    chk(rd_data === e, req, 32'(rd_data), 32'(e));
    chk(slave_rst == 2'b00, {req, " R7 pulse gone"}, 32'(slave_rst), 32'd0);
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom_range(0, 7))
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h10 + 8'($urandom_range(0, 1));
      3, 4: return 8'h20 + 8'($urandom_range(0, 15));
      5: return 8'hEC + 8'($urandom_range(0, 3));
      6: return 8'h3E;
      default: return 8'h84;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bus_valid = 0; bus_write = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    rst = 1;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    chk(adapter_en == 1'b0, "R1 enable low", 32'(adapter_en), 32'd0);
    chk(slave_rst == 2'b00, "R1 no pulse", 32'(slave_rst), 32'd0);
    rd(1, 8'h00, "R1 ctrl 0x0082");
    rd(1, 8'h10, "R1 len zero");
    rd(1, 8'h2A, "R1 comm zero");

    // R9 tag, R11 byte lanes
    rd(1, 8'hEC, "R9 tag MA");
    rd(1, 8'hEE, "R9 tag RS");
    rd(0, 8'hED, "R9 R11 tag byte A");
    rd(0, 8'hEE, "R9 R11 tag byte R");
    rd(0, 8'h00, "R11 ctrl high byte");
    rd(0, 8'h01, "R11 ctrl low byte");

    // R4 gated writes while disabled; R3 mailbox open
    wr(1, 8'h00, 16'h8002, "R4 ctrl word no enable");
    wr(0, 8'h00, 16'h0080, "R4 ctrl high byte");
    wr(1, 8'h10, 16'h1234, "R4 len gated");
    rd(1, 8'h00, "R4 ctrl unchanged");
    rd(1, 8'h10, "R4 R8 len unchanged");
    wr(1, 8'h20, 16'hBEEF, "R3 comm word");
    wr(0, 8'h25, 16'h005A, "R3 comm byte");
    wr(1, 8'hEC, 16'hFFFF, "R9 tag write");
    rd(1, 8'h20, "R3 comm word read");
    rd(1, 8'h24, "R3 comm byte in word");
    rd(0, 8'h21, "R3 R11 comm odd byte");
    rd(1, 8'hEC, "R9 tag after write");

    // R5 enable without release, then R7 release
    wr(0, 8'h01, 16'h0001, "R5 enable byte");
    rd(1, 8'h00, "R5 ctrl 0x0081");
    wr(0, 8'h01, 16'h0003, "R7 release pulse");
    rd(1, 8'h00, "R7 ctrl 0x0083");
    wr(0, 8'h01, 16'h0003, "R7 no repeat pulse");

    // R6 field updates after enable
    wr(1, 8'h00, 16'h0000, "R6 word clears nres");
    rd(1, 8'h00, "R6 enable sticky");
    wr(0, 8'h00, 16'h0080, "R6 byte fm");
    rd(1, 8'h00, "R6 fm only");
    wr(1, 8'h00, 16'h0002, "R6 R7 word release");
    rd(1, 8'h00, "R6 ctrl word");

    // R8 length
    wr(1, 8'h10, 16'hFFFF, "R8 len word");
    rd(1, 8'h10, "R8 len 0xFFFC");
    wr(0, 8'h11, 16'h0037, "R8 len low byte");
    wr(0, 8'h10, 16'h00A5, "R8 len high byte");
    rd(1, 8'h10, "R8 len bytes");

    // R10 unmapped
    wr(1, 8'h3E, 16'hFFFF, "R10 write unmapped");
    rd(1, 8'h3E, "R10 read unmapped");
    rd(1, 8'h84, "R10 read outside");

    // R5 enabling word write that also releases
    do_reset();
    rd(1, 8'h00, "R1 ctrl after reset");
    rd(1, 8'h24, "R1 comm after reset");
    wr(1, 8'h00, 16'h8003, "R5 enable and release");
    rd(1, 8'h00, "R5 ctrl 0x8083");

    // random phase
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      bit w;
      a = pick_addr();
      w = 1'($urandom_range(0, 1));
      if (n == 300 && !m_en) wr(1, 8'h00, 16'h0001, "R5 random enable");
      if ($urandom_range(0, 1) == 0) wr(w, a, 16'($urandom), "R3 R6 R8 random write");
      else rd(w, a, "R2 R11 random read");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule